// File: doc/BRIEF.md
# Serial Register-Bank Slave

This block lets an external SPI master read and write a local bank of 32 registers, each 16 bits wide. The bus runs in mode 0: the clock idles low, the slave samples MOSI on rising clock edges and changes MISO on falling edges. The block samples the serial clock, MOSI and the active-low select with its own system clock, which must run at least four times faster than the serial clock. All edge detection takes place in the system clock domain.

Every transaction is one 32-bit frame, sent MSB first. The first 16 bits are a command word and the last 16 bits are a data word. The command word has these fields:

- bits 15..12: a sync pattern, which must be `1010`.
- bit 11: a read flag.
- bit 10: a write flag.
- bits 9..5: reserved bits.
- bits 4..0: the register address.

For a read, the addressed register is fetched as soon as the 16th command bit arrives. It is shifted out on MISO during clocks 17 to 32 of the same frame. For a write, the data word is committed to the register once all 32 bits have arrived. When both flags are set, the old contents go out first and the new word then replaces them at the end of the frame.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, `miso_o` and `miso_oe_o` are 0, and every register reads back as 0x0000.
- R2: The sync field is bits 15..12 of the command word.
  - If it is not `1010`, the frame performs no write, and MISO stays 0 for the whole frame.
  - A command with both flags clear changes nothing and returns 0.
- R3: With the write flag (bit 11 clear, bit 10 set) and a matching sync field, the 16-bit data word is written to the register addressed by bits 4..0. The write happens only after the 32nd rising clock edge, and MISO stays 0 for the whole frame.
- R4: With the read flag (bit 11) set and a matching sync field, MISO is 0 during clocks 1 to 16. The addressed register is then presented MSB first during clocks 17 to 32, and each bit is valid at its rising edge.
- R5: With both flags set, clocks 17 to 32 return the register's previous contents, and the received data word replaces them at the end of the frame.
- R6: While the select input is high, `miso_oe_o` and `miso_o` are 0. Activity on SCLK and MOSI in that state does not change any register. While the select is low, `miso_oe_o` is 1.
- R7: Raising the select before 32 bits have been received aborts the frame without a write, and the next frame starts counting from bit 1.
- R8: The reserved bits 9..5 have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master, 0 when not reading |
| miso_oe_o | output | 1 | Output enable for the MISO pad, high while selected |

## Verification
Each fault shows up at the pins within at most one frame:

- A bit counter that is off by one shifts the returned word by one position, which is visible in the first read after the error.
- A sync or flag decoding error shows as a nonzero MISO word on a rejected frame, or as a register that changed when it should not have. Both are found by the very next read of that address.
- A write that is committed too early, or that is not suppressed on abort, leaves the wrong value in the register. The following read returns it.
- Combined read-write frames show whether the fetch happens before the commit, because they return the old value.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int NREG       = 1 << ADDR_W;
  localparam int CMD_W      = 16;
  localparam int FRAME_BITS = CMD_W + DATA_W;
  localparam int SYNC_W     = 4;
  localparam int RSVD_W     = CMD_W - SYNC_W - 2 - ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [SYNC_W-1:0] SYNC_PAT = 4'b1010;

  typedef struct packed {
    logic [SYNC_W-1:0] sync;
    logic              rd;
    logic              wr;
    logic [RSVD_W-1:0] rsvd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_w [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic              en;
      logic [DATA_W-1:0] val_q;
      assign en = we_i && (waddr_i == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= '0;
        else if (en) val_q <= wdata_i;
      end
      assign mem_w[g] = val_q;
    end
  endgenerate

  assign rdata_o = mem_w[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem_w[$past(waddr_i)] == $past(wdata_i)); // R3
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-2:0] rx_q, rx_n;
  logic              rd_ok_q, rd_ok_n;
  logic              wr_ok_q, wr_ok_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              load_q, load_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              dv_q, dv_n;
  logic              wr_en;

  logic [DATA_W-1:0] rx_shift;
  cmd_t              cmd_in;
  logic              sync_hit;
  logic              frame_full;
  logic              unused_rsvd;

  assign rx_shift    = {rx_q, mosi_i};
  assign cmd_in      = cmd_t'(rx_shift);
  assign sync_hit    = (cmd_in.sync == SYNC_PAT);
  assign frame_full  = (cnt_q == CNT_W'(FRAME_BITS));
  assign unused_rsvd = ^cmd_in.rsvd;

  always_comb begin
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    rd_ok_n = rd_ok_q;
    wr_ok_n = wr_ok_q;
    addr_n  = addr_q;
    load_n  = 1'b0;
    tx_n    = tx_q;
    dv_n    = dv_q;
    wr_en   = 1'b0;
    if (!cs_active_i) begin
      cnt_n   = '0;
      rd_ok_n = 1'b0;
      wr_ok_n = 1'b0;
      dv_n    = 1'b0;
      tx_n    = '0;
    end else begin
      if (sclk_rise_i && !frame_full) begin
        cnt_n = cnt_q + 1'b1;
        rx_n  = rx_shift[DATA_W-2:0];
        if (cnt_q == CNT_W'(CMD_W - 1)) begin
          rd_ok_n = cmd_in.rd && sync_hit;
          wr_ok_n = cmd_in.wr && sync_hit;
          addr_n  = cmd_in.addr;
          load_n  = 1'b1;
        end
        if (cnt_q == CNT_W'(FRAME_BITS - 1)) wr_en = wr_ok_q;
      end
      if (load_q) tx_n = rd_ok_q ? rd_data_i : '0;
      if (sclk_fall_i) begin
        if (cnt_q == CNT_W'(CMD_W))                 dv_n = rd_ok_q;
        else if (dv_q && (cnt_q > CNT_W'(CMD_W)))  tx_n = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      rd_ok_q <= 1'b0;
      wr_ok_q <= 1'b0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      tx_q    <= '0;
      dv_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      rd_ok_q <= rd_ok_n;
      wr_ok_q <= wr_ok_n;
      addr_q  <= addr_n;
      load_q  <= load_n;
      tx_q    <= tx_n;
      dv_q    <= dv_n;
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = rx_shift;
  assign wr_en_o   = wr_en;
  assign miso_o    = dv_q & tx_q[DATA_W-1];

  AST_CNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> cnt_q == '0); // R7
  AST_CMD_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CNT_W'(CMD_W)) |-> !miso_o); // R4
  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && cs_active_i && !sclk_fall_i) |=> $stable(miso_o)); // R4
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic csn_i,
  output logic miso_o,
  output logic miso_oe_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [2:0] pins_s;
  logic       sclk_s, mosi_s, csn_s;

  spi_rb_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({csn_i, mosi_i, sclk_i}),
    .q_o   (pins_s)
  );
  assign {csn_s, mosi_s, sclk_s} = pins_s;

  logic sclk_d_q, sclk_d_n;
  logic sclk_rise, sclk_fall, cs_active;

  assign sclk_d_n  = sclk_s;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sclk_d_q <= 1'b0;
    else            sclk_d_q <= sclk_d_n;
  end
  assign cs_active = !csn_s;
  assign sclk_rise = cs_active &&  sclk_s && !sclk_d_q;
  assign sclk_fall = cs_active && !sclk_s &&  sclk_d_q;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, miso_bit;

  spi_rb_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_active_i (cs_active),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .mosi_i      (mosi_s),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .miso_o      (miso_bit)
  );

  spi_rb_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign miso_o    = cs_active & miso_bit;
  assign miso_oe_o = cs_active;

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !miso_oe_o |-> !miso_o); // R6
  AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_int_n)
    csn_s |-> !wr_en); // R6
endmodule

// File: tb/sim_spi_regbank_slave.sv
module sim_spi_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 8;
  localparam int HALF_T     = HALF_CLKS * CLK_PERIOD;

  logic clk, rst_n, sclk, mosi, csn, miso, miso_oe;
  int   checks, errors;
  bit   finished;

  logic [15:0] model [32];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];

  spi_regbank_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .mosi_i    (mosi),
    .csn_i     (csn),
    .miso_o    (miso),
    .miso_oe_o (miso_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit rd, input bit wr, input logic [4:0] addr,
                                     input logic [4:0] rsvd = 5'd0,
                                     input logic [3:0] syn = 4'b1010);
    return {syn, rd, wr, rsvd, addr};
  endfunction

  task automatic run_frame(input logic [15:0] cmd, input logic [15:0] data,
                           input int nbits, input string tag);
    logic [31:0] word;
    logic [31:0] got;
    bit          hit;
    logic [4:0]  addr;
    word = {cmd, data};
    got  = '0;
    hit  = (cmd[15:12] == 4'b1010);
    addr = cmd[4:0];
    if (nbits == 32) begin
      exp_q.push_back((cmd[11] && hit) ? {16'h0000, model[addr]} : 32'h0);
      tag_q.push_back(tag);
    end
    csn  = 1'b0;
    mosi = word[31];
    #(HALF_T);
    check(miso_oe == 1'b1, "R6 oe while selected", {31'b0, miso_oe}, 32'h1);
    for (int i = 0; i < nbits; i++) begin
      got[31-i] = miso;
      sclk = 1'b1;
      #(HALF_T);
      sclk = 1'b0;
      if (i < 31) mosi = word[30-i];
      #(HALF_T);
    end
    csn  = 1'b1;
    mosi = 1'b0;
    #(2*HALF_T);
    if (nbits == 32) begin
      act_q.push_back(got);
      if (cmd[10] && hit) model[addr] = data;
    end
  endtask

  initial begin : monitor
    logic [31:0] a, e;
    string t;
    forever begin
      wait (act_q.size() != 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(a === e, t, a, e);
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    checks = 0;
    errors = 0;
    finished = 0;
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    sclk = 1'b0; mosi = 1'b0; csn = 1'b1; rst_n = 1'b0;
    #(CLK_PERIOD * 5);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    #(CLK_PERIOD * 6);
    check(miso == 1'b0, "R1 miso after reset", {31'b0, miso}, 32'h0);
    check(miso_oe == 1'b0, "R1 oe after reset", {31'b0, miso_oe}, 32'h0);

    run_frame(mk(1, 0, 5'd0),  16'h0000, 32, "R1 reset value reg0");
    run_frame(mk(1, 0, 5'd31), 16'h0000, 32, "R1 reset value reg31");

    run_frame(mk(0, 1, 5'd3),  16'h7878, 32, "R3 write-only frame returns zero");
    run_frame(mk(1, 0, 5'd3),  16'h0000, 32, "R4 read reg3");
    run_frame(mk(0, 1, 5'd31), 16'h8001, 32, "R3 write reg31");
    run_frame(mk(0, 1, 5'd0),  16'hFFFF, 32, "R3 write reg0");
    run_frame(mk(1, 0, 5'd31), 16'h0000, 32, "R4 read reg31 msb/lsb");
    run_frame(mk(1, 0, 5'd0),  16'h0000, 32, "R4 read reg0 all ones");

    run_frame(mk(1, 1, 5'd3),  16'hA5C3, 32, "R5 rd+wr returns old value");
    run_frame(mk(1, 0, 5'd3),  16'h0000, 32, "R5 new value stored");

    run_frame(mk(0, 1, 5'd5, 5'd0, 4'b1011), 16'hBEEF, 32, "R2 bad sync write");
    run_frame(mk(1, 0, 5'd3, 5'd0, 4'b0101), 16'h0000, 32, "R2 bad sync read is zero");
    run_frame(mk(1, 0, 5'd5),  16'h0000, 32, "R2 reg5 untouched by bad sync");
    run_frame(mk(0, 0, 5'd3),  16'h1111, 32, "R2 no-flag frame");
    run_frame(mk(1, 0, 5'd3),  16'h0000, 32, "R2 reg3 untouched by no-flag frame");

    run_frame(mk(0, 1, 5'd12, 5'h1F), 16'h3C5A, 32, "R8 reserved bits set on write");
    run_frame(mk(1, 0, 5'd12, 5'h15), 16'h0000, 32, "R8 reserved bits set on read");

    run_frame(mk(0, 1, 5'd9),  16'h1234, 32, "R3 write reg9");
    csn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      mosi = ~mosi;
      sclk = 1'b1;
      #(HALF_T);
      check(miso_oe == 1'b0 && miso == 1'b0, "R6 idle outputs low",
            {30'b0, miso_oe, miso}, 32'h0);
      sclk = 1'b0;
      #(HALF_T);
    end
    mosi = 1'b0;
    run_frame(mk(1, 0, 5'd9),  16'h0000, 32, "R6 reg9 unchanged by unselected clocks");

    run_frame(mk(0, 1, 5'd9),  16'hDEAD, 24, "R7 aborted at 24 bits");
    run_frame(mk(0, 1, 5'd9),  16'hDEAD, 31, "R7 aborted at 31 bits");
    run_frame(mk(1, 0, 5'd9),  16'h0000, 32, "R7 reg9 unchanged after abort");
    run_frame(mk(1, 1, 5'd9),  16'h0F0F, 32, "R7 full frame after abort");
    run_frame(mk(1, 0, 5'd9),  16'h0000, 32, "R7 written after abort recovery");

    wait (act_q.size() == 0);
    #(CLK_PERIOD * 4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule